// File: doc/BRIEF.md
# CAN Error State Classifier

This block sits beside a CAN protocol engine and turns the engine's raw error information into a fault-confinement verdict. Each cycle it samples the transmit and receive error counters, a bus-off indication from the engine, and single-cycle protocol-error pulses. It registers a state code (active, warning, passive or bus-off), an error-flag byte, a status byte and a one-cycle indication of which direction, transmit or receive, a state change is attributed to.

Protocol errors are kept as sticky flags until a read pulse clears them. A priority encoder reports the one cause that matters most. An interrupt-flag register collects the block's own bus-error event together with the other event sources of the controller. Each flag can be cleared on its own by a write-one-to-clear vector. An enable mask qualifies the interrupt line. The counter update rules belong to the engine and are not part of this block.

Top module: `can_esc_top`

## Requirements
- R1: After reset, state_o is 0, err_flags_o, int_flags_o and stat_o are 0, irq_o is 0, cause_o is 0 (none) and both direction pulses are low.
- R2: One cycle after the inputs are sampled, state_o is computed by fixed priority. It is 3 (bus-off) when bus_off_i is high. Otherwise it is 2 (passive) when tec_i or rec_i is at least 128. Otherwise it is 1 (warning) when either counter is at least 96. Otherwise it is 0 (active).
- R3: Error-flag bits 7, 6 and 5 are registered copies of bus_off_i, tec_i >= 128 and rec_i >= 128.
- R4: A pulse on prot_err_i sets the matching sticky error-flag bit. The positions are bit 4 bit error, bit 3 form, bit 2 CRC, bit 1 ACK and bit 0 stuff. err_rd_i clears bits 4..0. A pulse that arrives in the same cycle as err_rd_i is kept.
- R5: cause_o reports the highest-priority sticky protocol error, in the order bit (1), form (2), stuff (3), CRC (4), ACK (5). It reports 0 when none is set.
- R6: When state_o changes, chg_tx_o pulses for one cycle if tec_i >= rec_i, and chg_rx_o pulses if tec_i <= rec_i. Both pulse when the counters are equal. Neither pulses without a change.
- R7: Interrupt-flag bit 4 is set by any protocol-error pulse or any state change. Every bit i of int_flags_o is also set by evt_i[i].
- R8: An interrupt flag stays set until its int_clr_i bit is high. A set and a clear in the same cycle leave the flag set.
- R9: irq_o is high exactly when some bit of int_flags_o has its int_en_i bit set. It follows int_en_i in the same cycle.
- R10: stat_o bit 2 is bus-off, bit 3 is passive (either counter >= 128) and bit 4 is warning (either counter >= 96). All other stat_o bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tec_i | input | 8 | Transmit error counter |
| rec_i | input | 8 | Receive error counter |
| bus_off_i | input | 1 | Engine reports bus-off |
| prot_err_i | input | 5 | Protocol error pulses (bit, form, CRC, ACK, stuff) |
| err_rd_i | input | 1 | Clears sticky protocol error flags |
| evt_i | input | 8 | Other interrupt event pulses |
| int_clr_i | input | 8 | Write-one-to-clear for interrupt flags |
| int_en_i | input | 8 | Interrupt enable mask |
| state_o | output | 2 | Fault-confinement state code |
| err_flags_o | output | 8 | Error-flag byte |
| stat_o | output | 8 | Status byte |
| cause_o | output | 3 | Prioritised protocol error cause |
| chg_tx_o | output | 1 | State change attributed to transmit |
| chg_rx_o | output | 1 | State change attributed to receive |
| int_flags_o | output | 8 | Interrupt flags |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions watch properties that hold on every cycle. They check that the state code agrees with the bus-off and passive flags and that a direction pulse coincides with an actual state change. They also check that a changed state always leaves the bus-error interrupt flag raised, that sticky protocol and interrupt flags only drop when cleared, and that a masked-off enable keeps the line low. The directed scenarios cover what needs chosen stimulus. These are the counter thresholds at 95/96 and 127/128, the attribution on equal counters, the cause ordering across mixed error bursts, a read that coincides with a new error, and a clear that coincides with a new event.

// File: rtl/can_esc_pkg.sv
package can_esc_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_WARN    = 2'd1,
    ST_PASSIVE = 2'd2,
    ST_BUSOFF  = 2'd3
  } flt_state_e;

  typedef enum logic [2:0] {
    CZ_NONE  = 3'd0,
    CZ_BIT   = 3'd1,
    CZ_FORM  = 3'd2,
    CZ_STUFF = 3'd3,
    CZ_CRC   = 3'd4,
    CZ_ACK   = 3'd5
  } err_cause_e;

  // positions inside the protocol error field
  localparam int unsigned PE_STUFF = 0;
  localparam int unsigned PE_ACK   = 1;
  localparam int unsigned PE_CRC   = 2;
  localparam int unsigned PE_FORM  = 3;
  localparam int unsigned PE_BIT   = 4;
  localparam int unsigned PE_W     = 5;

endpackage

// File: rtl/can_esc_state.sv
module can_esc_state
  import can_esc_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned WARN_LIM = 96,
  parameter int unsigned PASS_LIM = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tec_i,
  input  logic [CNT_W-1:0] rec_i,
  input  logic             bus_off_i,
  output flt_state_e       state_o,
  output logic             boff_o,
  output logic             txp_o,
  output logic             rxp_o,
  output logic             warn_o,
  output logic             chg_d_o,
  output logic             chg_tx_o,
  output logic             chg_rx_o
);

  localparam logic [CNT_W-1:0] WARN_L = WARN_LIM[CNT_W-1:0];
  localparam logic [CNT_W-1:0] PASS_L = PASS_LIM[CNT_W-1:0];

  flt_state_e state_q, state_d;
  logic txp_d, rxp_d, warn_d;
  logic boff_q, txp_q, rxp_q, warn_q;
  logic chg_tx_q, chg_rx_q;

  always_comb begin
    txp_d  = (tec_i >= PASS_L);
    rxp_d  = (rec_i >= PASS_L);
    warn_d = (tec_i >= WARN_L) || (rec_i >= WARN_L);
    if (bus_off_i)          state_d = ST_BUSOFF;
    else if (txp_d | rxp_d) state_d = ST_PASSIVE;
    else if (warn_d)        state_d = ST_WARN;
    else                    state_d = ST_ACTIVE;
  end

  assign chg_d_o = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_ACTIVE;
      boff_q   <= 1'b0;
      txp_q    <= 1'b0;
      rxp_q    <= 1'b0;
      warn_q   <= 1'b0;
      chg_tx_q <= 1'b0;
      chg_rx_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      boff_q   <= bus_off_i;
      txp_q    <= txp_d;
      rxp_q    <= rxp_d;
      warn_q   <= warn_d;
      // attribution: ties go to both directions
      chg_tx_q <= chg_d_o && (tec_i >= rec_i);
      chg_rx_q <= chg_d_o && (tec_i <= rec_i);
    end
  end

  assign state_o  = state_q;
  assign boff_o   = boff_q;
  assign txp_o    = txp_q;
  assign rxp_o    = rxp_q;
  assign warn_o   = warn_q;
  assign chg_tx_o = chg_tx_q;
  assign chg_rx_o = chg_rx_q;

endmodule

// File: rtl/can_esc_prot.sv
module can_esc_prot
  import can_esc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PE_W-1:0] pulse_i,
  input  logic            rd_i,
  output logic [PE_W-1:0] sticky_o,
  output err_cause_e      cause_o
);

  logic [PE_W-1:0] sticky_q;

  // new pulse wins over a coincident read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= pulse_i | (rd_i ? '0 : sticky_q);
  end

  always_comb begin
    if      (sticky_q[PE_BIT])   cause_o = CZ_BIT;
    else if (sticky_q[PE_FORM])  cause_o = CZ_FORM;
    else if (sticky_q[PE_STUFF]) cause_o = CZ_STUFF;
    else if (sticky_q[PE_CRC])   cause_o = CZ_CRC;
    else if (sticky_q[PE_ACK])   cause_o = CZ_ACK;
    else                         cause_o = CZ_NONE;
  end

  assign sticky_o = sticky_q;

endmodule

// File: rtl/can_esc_irq.sv
module can_esc_irq #(
  parameter int unsigned NUM_INT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_INT-1:0] set_i,
  input  logic [NUM_INT-1:0] clr_i,
  input  logic [NUM_INT-1:0] en_i,
  output logic [NUM_INT-1:0] flags_o,
  output logic               irq_o
);

  logic [NUM_INT-1:0] flag_q;

  for (genvar i = 0; i < NUM_INT; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= set_i[i] | (flag_q[i] & ~clr_i[i]);
    end
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & en_i);

endmodule

// File: rtl/can_esc_top.sv
module can_esc_top
  import can_esc_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned WARN_LIM    = 96,
  parameter int unsigned PASS_LIM    = 128,
  parameter int unsigned NUM_INT     = 8,
  parameter int unsigned INT_BUS_BIT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   tec_i,
  input  logic [CNT_W-1:0]   rec_i,
  input  logic               bus_off_i,
  input  logic [4:0]         prot_err_i,
  input  logic               err_rd_i,
  input  logic [NUM_INT-1:0] evt_i,
  input  logic [NUM_INT-1:0] int_clr_i,
  input  logic [NUM_INT-1:0] int_en_i,
  output logic [1:0]         state_o,
  output logic [7:0]         err_flags_o,
  output logic [7:0]         stat_o,
  output logic [2:0]         cause_o,
  output logic               chg_tx_o,
  output logic               chg_rx_o,
  output logic [NUM_INT-1:0] int_flags_o,
  output logic               irq_o
);

  flt_state_e      state;
  err_cause_e      cause;
  logic            boff, txp, rxp, warn, chg_d;
  logic [PE_W-1:0] sticky;
  logic [NUM_INT-1:0] int_set;

  can_esc_state #(
    .CNT_W   (CNT_W),
    .WARN_LIM(WARN_LIM),
    .PASS_LIM(PASS_LIM)
  ) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tec_i    (tec_i),
    .rec_i    (rec_i),
    .bus_off_i(bus_off_i),
    .state_o  (state),
    .boff_o   (boff),
    .txp_o    (txp),
    .rxp_o    (rxp),
    .warn_o   (warn),
    .chg_d_o  (chg_d),
    .chg_tx_o (chg_tx_o),
    .chg_rx_o (chg_rx_o)
  );

  can_esc_prot u_prot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (prot_err_i),
    .rd_i    (err_rd_i),
    .sticky_o(sticky),
    .cause_o (cause)
  );

  always_comb begin
    int_set = evt_i;
    int_set[INT_BUS_BIT] = evt_i[INT_BUS_BIT] | (|prot_err_i) | chg_d;
  end

  can_esc_irq #(
    .NUM_INT(NUM_INT)
  ) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (int_set),
    .clr_i  (int_clr_i),
    .en_i   (int_en_i),
    .flags_o(int_flags_o),
    .irq_o  (irq_o)
  );

  assign state_o     = state;
  assign cause_o     = cause;
  assign err_flags_o = {boff, txp, rxp, sticky};
  assign stat_o      = {3'b000, warn, txp | rxp, boff, 2'b00};

endmodule

// File: rtl/can_esc_chk.sv
module can_esc_chk #(
  parameter int unsigned NUM_INT = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               err_rd_i,
  input logic [4:0]         prot_err_i,
  input logic [NUM_INT-1:0] int_clr_i,
  input logic [NUM_INT-1:0] int_en_i,
  input logic [1:0]         state_o,
  input logic [7:0]         err_flags_o,
  input logic [7:0]         stat_o,
  input logic [2:0]         cause_o,
  input logic               chg_tx_o,
  input logic               chg_rx_o,
  input logic [NUM_INT-1:0] int_flags_o,
  input logic               irq_o
);

  // R2
  busoff_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flags_o[7] |-> state_o == 2'd3);

  // R2
  passive_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_flags_o[7] && (err_flags_o[6] || err_flags_o[5])) |-> state_o == 2'd2);

  // R10
  warn_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1) |-> (stat_o[4] && !stat_o[3] && !stat_o[2]));

  // R6
  chg_real_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_tx_o || chg_rx_o) |-> state_o != $past(state_o));

  // R6
  chg_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != $past(state_o)) |-> (chg_tx_o || chg_rx_o));

  // R7
  chg_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_tx_o || chg_rx_o) |-> int_flags_o[4]);

  // R4
  prot_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_err_i != 5'd0) |=> ((err_flags_o[4:0] & $past(prot_err_i)) == $past(prot_err_i)));

  // R4
  prot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_rd_i |=> ((~err_flags_o[4:0] & $past(err_flags_o[4:0])) == 5'd0));

  // R5
  cause_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_flags_o[4] |-> cause_o == 3'd1);

  // R8
  int_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~int_flags_o & $past(int_flags_o) & ~$past(int_clr_i)) == '0));

  // R9
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_en_i == '0) |-> !irq_o);

endmodule

bind can_esc_top can_esc_chk #(.NUM_INT(NUM_INT)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .err_rd_i   (err_rd_i),
  .prot_err_i (prot_err_i),
  .int_clr_i  (int_clr_i),
  .int_en_i   (int_en_i),
  .state_o    (state_o),
  .err_flags_o(err_flags_o),
  .stat_o     (stat_o),
  .cause_o    (cause_o),
  .chg_tx_o   (chg_tx_o),
  .chg_rx_o   (chg_rx_o),
  .int_flags_o(int_flags_o),
  .irq_o      (irq_o)
);

// File: tb/can_esc_top_tb_top.sv
module can_esc_top_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] tec_i = '0;
  logic [7:0] rec_i = '0;
  logic       bus_off_i = 1'b0;
  logic [4:0] prot_err_i = '0;
  logic       err_rd_i = 1'b0;
  logic [7:0] evt_i = '0;
  logic [7:0] int_clr_i = '0;
  logic [7:0] int_en_i = '0;
  logic [1:0] state_o;
  logic [7:0] err_flags_o;
  logic [7:0] stat_o;
  logic [2:0] cause_o;
  logic       chg_tx_o;
  logic       chg_rx_o;
  logic [7:0] int_flags_o;
  logic       irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  can_esc_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tec_i(tec_i), .rec_i(rec_i),
    .bus_off_i(bus_off_i), .prot_err_i(prot_err_i), .err_rd_i(err_rd_i),
    .evt_i(evt_i), .int_clr_i(int_clr_i), .int_en_i(int_en_i),
    .state_o(state_o), .err_flags_o(err_flags_o), .stat_o(stat_o),
    .cause_o(cause_o), .chg_tx_o(chg_tx_o), .chg_rx_o(chg_rx_o),
    .int_flags_o(int_flags_o), .irq_o(irq_o)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic clr_ints();
    int_clr_i = 8'hFF;
    tick();
    int_clr_i = 8'h00;
  endtask

  task automatic set_cnt(input int t, input int r, input bit bo);
    tec_i = t[7:0];
    rec_i = r[7:0];
    bus_off_i = bo;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 state", state_o, 0);
    chk("R1 err_flags", err_flags_o, 0);
    chk("R1 int_flags", int_flags_o, 0);
    chk("R1 stat", stat_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 cause", cause_o, 0);
    chk("R1 chg", {chg_tx_o, chg_rx_o}, 0);
  endtask

  task automatic t_state();
    set_cnt(50, 10, 0);
    chk("R2 active low counts", state_o, 0);
    chk("R6 no change", {chg_tx_o, chg_rx_o}, 0);
    set_cnt(96, 10, 0);
    chk("R2 warning at 96", state_o, 1);
    chk("R6 tx attributed", {chg_tx_o, chg_rx_o}, 2'b10);
    chk("R7 bus int on change", int_flags_o, 8'h10);
    chk("R10 warn stat", stat_o, 8'h10);
    tick();
    chk("R6 pulse one cycle", {chg_tx_o, chg_rx_o}, 0);
    clr_ints();
    chk("R8 cleared", int_flags_o, 0);
    set_cnt(95, 95, 0);
    chk("R2 active at 95", state_o, 0);
    chk("R6 equal both", {chg_tx_o, chg_rx_o}, 2'b11);
    set_cnt(95, 127, 0);
    chk("R2 warning rec 127", state_o, 1);
    chk("R6 rx attributed", {chg_tx_o, chg_rx_o}, 2'b01);
    set_cnt(95, 128, 0);
    chk("R2 passive rec 128", state_o, 2);
    chk("R3 rx passive flag", err_flags_o, 8'h20);
    chk("R10 passive stat", stat_o, 8'h18);
    set_cnt(200, 128, 0);
    chk("R2 still passive", state_o, 2);
    chk("R3 both passive", err_flags_o, 8'h60);
    chk("R6 no pulse same state", {chg_tx_o, chg_rx_o}, 0);
    set_cnt(200, 128, 1);
    chk("R2 bus-off wins", state_o, 3);
    chk("R3 bus-off flag", err_flags_o, 8'hE0);
    chk("R10 bus-off stat", stat_o, 8'h1C);
    chk("R6 tx on bus-off", {chg_tx_o, chg_rx_o}, 2'b10);
    set_cnt(0, 0, 0);
    chk("R2 back to active", state_o, 0);
    chk("R3 flags drop", err_flags_o, 0);
    tick();
    clr_ints();
  endtask

  task automatic pulse_prot(input logic [4:0] v, input bit rd);
    prot_err_i = v;
    err_rd_i = rd;
    tick();
    prot_err_i = '0;
    err_rd_i = 1'b0;
  endtask

  task automatic t_prot();
    pulse_prot(5'b00101, 0);
    chk("R4 crc+stuff sticky", err_flags_o, 8'h05);
    chk("R5 stuff beats crc", cause_o, 3);
    chk("R7 bus int on prot err", int_flags_o, 8'h10);
    tick();
    chk("R4 held", err_flags_o, 8'h05);
    pulse_prot(5'b01000, 0);
    chk("R5 form beats stuff", cause_o, 2);
    pulse_prot(5'b00010, 1);
    chk("R4 read keeps new ack", err_flags_o, 8'h02);
    chk("R5 ack alone", cause_o, 5);
    pulse_prot(5'b00000, 1);
    chk("R4 read clears", err_flags_o, 0);
    chk("R5 none", cause_o, 0);
    pulse_prot(5'b10010, 0);
    chk("R5 bit highest", cause_o, 1);
    pulse_prot(5'b00000, 1);
    pulse_prot(5'b00100, 0);
    chk("R5 crc alone", cause_o, 4);
    pulse_prot(5'b00000, 1);
    clr_ints();
  endtask

  task automatic t_irq();
    int_en_i = 8'h00;
    evt_i = 8'h81;
    tick();
    evt_i = 8'h00;
    chk("R7 event flags", int_flags_o, 8'h81);
    chk("R9 masked", irq_o, 0);
    int_en_i = 8'h01;
    #1;
    chk("R9 enabled bit0", irq_o, 1);
    int_en_i = 8'h7E;
    #1;
    chk("R9 no overlap", irq_o, 0);
    int_en_i = 8'h80;
    int_clr_i = 8'h01;
    tick();
    int_clr_i = 8'h00;
    chk("R8 single clear", int_flags_o, 8'h80);
    chk("R9 bit7 enabled", irq_o, 1);
    int_clr_i = 8'h80;
    evt_i = 8'h80;
    tick();
    int_clr_i = 8'h00;
    evt_i = 8'h00;
    chk("R8 set wins over clear", int_flags_o, 8'h80);
    tick();
    chk("R8 held", int_flags_o, 8'h80);
    int_clr_i = 8'h80;
    tick();
    int_clr_i = 8'h00;
    chk("R8 cleared bit7", int_flags_o, 0);
    chk("R9 low after clear", irq_o, 0);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_state();
    t_prot();
    t_irq();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule